// File: doc/BRIEF.md
# Two-Way Set-Associative Byte Cache with Write-Back and Write-Through Modes

This block sits between a processor that issues single-byte loads and stores and a byte-addressed backing memory that moves data in multi-byte blocks. Each set has two ways. Every line keeps a valid flag, a modified flag, a tag and one block of data, and each set keeps one bit that names the way to replace next. The processor raises a request and holds its address, direction and store byte steady until the block returns a one-cycle completion strobe. Load data is valid during that strobe.

With the default write-back policy a store touches only the cached copy and marks the line modified. A modified line goes back to memory as a whole block only when it is chosen for replacement, and that write finishes before the refill read starts. A clean victim is simply overwritten. A store miss first brings the block in and then updates the addressed byte. A parameter switches the block to write-through. In that mode every store also sends its single byte to memory and no line is ever marked modified. Four running counters expose hits, misses, bytes read from memory and bytes written to memory.

Top module: `wb2_cache`

## Requirements
- R1: After reset all lines are invalid, all four counters read zero, no memory request is raised, the completion strobe is low, and the first access to any address is a miss.
- R2: A load to a resident block returns the stored byte with the completion strobe, adds one to the hit counter and causes no memory traffic.
- R3: A miss adds one to the miss counter and reads one whole block: a request with write-enable low and the block-aligned address (low offset bits zero). When the acknowledge arrives, the bytes-read counter grows by the block size (2 by default).
- R4: In write-back mode a store changes only the cached copy: memory keeps its old byte until the line is replaced, and later loads return the new byte.
- R5: When a modified line is replaced in write-back mode, the whole block goes to memory with every byte-enable bit set. This write completes before the refill read is issued, and the bytes-written counter grows by the block size.
- R6: A victim that was never stored into since it was filled is dropped without any memory write.
- R7: In write-through mode every store issues one memory write whose byte-enable is one-hot at the byte offset (bit 0 for the lower address). Memory then always matches the processor's view, and the bytes-written counter grows by one per store.
- R8: A store miss allocates: the block is read in, then the addressed byte is updated in the cache, so a following load to that byte hits and returns the stored value.
- R9: The victim in a full set is the way used least recently. Every hit and every fill makes the way it touched the most recent one.
- R10: For the byte accesses load 1, load 7, store 0, store 5, load 10 from reset with one set, both modes count 4 misses, 1 hit and 8 bytes read. Write-back has written 2 bytes at that point, and 4 bytes once a further miss replaces the remaining modified block. Write-through has written 2 bytes.
- R11: Each request gets exactly one completion strobe, one cycle wide. A memory request keeps its address and direction steady until its acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req | input | 1 | Processor access request, held until completion |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address of the access |
| cpu_wdata | input | 8 | Byte to store |
| cpu_done | output | 1 | One-cycle completion strobe |
| cpu_rdata | output | 8 | Load data, valid with cpu_done |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | 1 = write, 0 = block read |
| mem_addr | output | ADDR_W | Block-aligned memory address |
| mem_be | output | BLK_BYTES | Byte enables of a write |
| mem_wdata | output | 8*BLK_BYTES | Write data, byte i in bits 8i+7..8i |
| mem_rdata | input | 8*BLK_BYTES | Block read data, valid with mem_ack |
| mem_ack | input | 1 | One-cycle acknowledge from memory |
| hit_count | output | CNT_W | Number of hits |
| miss_count | output | CNT_W | Number of misses |
| rd_bytes | output | CNT_W | Bytes read from memory |
| wr_bytes | output | CNT_W | Bytes written to memory |

## Verification
A wrong replacement bit or a lost tag shows up as an extra miss on the very next access to the affected set. The miss counter and the bytes-read counter change at that access's completion, so the error is caught within one transaction. A modified flag that is set wrongly or dropped stays hidden until that line is replaced. It then appears as a changed or missing write-back in the bytes-written counter, and as a stale or wrong byte in the backing memory image, which is compared whole after every access. Corrupt line data appears at the first load of that byte as a wrong value on the read-data port. In write-through mode the same corruption also appears in memory at once.

// File: rtl/wb2_pkg.sv
package wb2_pkg;

    // Controller phases of one processor access.
    typedef enum logic [1:0] {
        CS_IDLE  = 2'd0,   // look up, answer hits, pick victim on a miss
        CS_EVICT = 2'd1,   // write modified victim block to memory
        CS_FILL  = 2'd2,   // read the missing block
        CS_WTWR  = 2'd3    // write-through byte store to memory
    } cstate_e;

    localparam int unsigned WAYS = 2;

endpackage

// File: rtl/wb2_way_match.sv
module wb2_way_match #(
    parameter int TAG_W = 2,
    parameter int WAYS  = 2
) (
    input  logic [WAYS-1:0]            valid,
    input  logic [WAYS-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]           probe,
    output logic [WAYS-1:0]            hit
);

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign hit[w] = valid[w] && (tags[w] == probe);
    end

endmodule

// File: rtl/wb2_victim_sel.sv
module wb2_victim_sel (
    input  logic [1:0] valid,
    input  logic       lru_way,
    output logic       victim
);

    // An empty way is filled first; otherwise the least recently used way.
    always_comb begin
        if (!valid[0]) begin
            victim = 1'b0;
        end else if (!valid[1]) begin
            victim = 1'b1;
        end else begin
            victim = lru_way;
        end
    end

endmodule

// File: rtl/wb2_byte_lane.sv
module wb2_byte_lane #(
    parameter int BLK_BYTES = 2,
    localparam int OFF_W    = $clog2(BLK_BYTES),
    localparam int BLK_W    = 8 * BLK_BYTES
) (
    input  logic [BLK_W-1:0]     blk,
    input  logic [OFF_W-1:0]     off,
    input  logic [7:0]           wbyte,
    output logic [7:0]           rbyte,
    output logic [BLK_W-1:0]     merged,
    output logic [BLK_BYTES-1:0] lane
);

    for (genvar i = 0; i < BLK_BYTES; i++) begin : g_lane
        assign lane[i]           = (off == OFF_W'(i));
        assign merged[i*8 +: 8]  = lane[i] ? wbyte : blk[i*8 +: 8];
    end

    always_comb begin
        rbyte = '0;
        for (int i = 0; i < BLK_BYTES; i++) begin
            if (lane[i]) begin
                rbyte = blk[i*8 +: 8];
            end
        end
    end

endmodule

// File: rtl/wb2_cache.sv
module wb2_cache
    import wb2_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int BLK_BYTES  = 2,
    parameter int SETS       = 1,
    parameter bit WRITE_BACK = 1'b1,
    parameter int CNT_W      = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cpu_req,
    input  logic                   cpu_we,
    input  logic [ADDR_W-1:0]      cpu_addr,
    input  logic [7:0]             cpu_wdata,
    output logic                   cpu_done,
    output logic [7:0]             cpu_rdata,
    output logic                   mem_req,
    output logic                   mem_we,
    output logic [ADDR_W-1:0]      mem_addr,
    output logic [BLK_BYTES-1:0]   mem_be,
    output logic [8*BLK_BYTES-1:0] mem_wdata,
    input  logic [8*BLK_BYTES-1:0] mem_rdata,
    input  logic                   mem_ack,
    output logic [CNT_W-1:0]       hit_count,
    output logic [CNT_W-1:0]       miss_count,
    output logic [CNT_W-1:0]       rd_bytes,
    output logic [CNT_W-1:0]       wr_bytes
);

    localparam int OFF_W    = $clog2(BLK_BYTES);
    localparam int IDX_BITS = $clog2(SETS);
    localparam int SET_W    = (IDX_BITS > 0) ? IDX_BITS : 1;
    localparam int TAG_W    = ADDR_W - OFF_W - IDX_BITS;
    localparam int BLK_W    = 8 * BLK_BYTES;

    typedef struct packed {
        cstate_e                            st;
        logic [SETS-1:0][WAYS-1:0]          valid;
        logic [SETS-1:0][WAYS-1:0]          dirty;
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag;
        logic [SETS-1:0][WAYS-1:0][BLK_W-1:0] data;
        logic [SETS-1:0]                    lru;      // way to replace next
        logic                               victim;   // way chosen for the open miss
        logic                               pending;  // open request already counted as a miss
        logic                               done;
        logic [7:0]                         rdata;
        logic [ADDR_W-1:0]                  maddr;
        logic                               mwe;
        logic [BLK_BYTES-1:0]               mbe;
        logic [BLK_W-1:0]                   mwdata;
        logic [CNT_W-1:0]                   hits;
        logic [CNT_W-1:0]                   misses;
        logic [CNT_W-1:0]                   rdb;
        logic [CNT_W-1:0]                   wrb;
    } regs_t;

    regs_t q, d;

    // Address fields of the current request.
    logic [SET_W-1:0] sidx;
    logic [TAG_W-1:0] ptag;
    logic [OFF_W-1:0] poff;

    always_comb begin
        ptag = cpu_addr[ADDR_W-1 -: TAG_W];
        poff = cpu_addr[OFF_W-1:0];
        if (IDX_BITS > 0) begin
            sidx = cpu_addr[OFF_W +: SET_W];
        end else begin
            sidx = '0;
        end
    end

    // Block-aligned address from a tag and the current set.
    function automatic logic [ADDR_W-1:0] blk_addr(input logic [TAG_W-1:0] t,
                                                   input logic [SET_W-1:0] s);
        logic [ADDR_W-1:0] a;
        a = '0;
        if (IDX_BITS > 0) begin
            a[OFF_W +: SET_W] = s;
        end
        a[ADDR_W-1 -: TAG_W] = t;
        return a;
    endfunction

    // Lookup in the addressed set.
    logic [WAYS-1:0] hit_vec;
    logic            hit_any;
    logic            hit_way;
    logic            victim_way;

    wb2_way_match #(.TAG_W(TAG_W), .WAYS(WAYS)) u_match (
        .valid (q.valid[sidx]),
        .tags  (q.tag[sidx]),
        .probe (ptag),
        .hit   (hit_vec)
    );

    assign hit_any = |hit_vec;
    assign hit_way = hit_vec[1];

    wb2_victim_sel u_victim (
        .valid   (q.valid[sidx]),
        .lru_way (q.lru[sidx]),
        .victim  (victim_way)
    );

    // Byte extraction and merge on the hitting line.
    logic [7:0]           lane_rbyte;
    logic [BLK_W-1:0]     lane_merged;
    logic [BLK_BYTES-1:0] lane_sel;

    wb2_byte_lane #(.BLK_BYTES(BLK_BYTES)) u_lane (
        .blk    (q.data[sidx][hit_way]),
        .off    (poff),
        .wbyte  (cpu_wdata),
        .rbyte  (lane_rbyte),
        .merged (lane_merged),
        .lane   (lane_sel)
    );

    logic active;
    assign active = cpu_req && !q.done;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            CS_IDLE: begin
                if (active) begin
                    if (hit_any) begin
                        if (!q.pending) begin
                            d.hits = q.hits + CNT_W'(1);
                        end
                        d.pending    = 1'b0;
                        d.lru[sidx]  = ~hit_way;
                        if (!cpu_we) begin
                            d.rdata = lane_rbyte;
                            d.done  = 1'b1;
                        end else begin
                            d.data[sidx][hit_way] = lane_merged;
                            if (WRITE_BACK) begin
                                d.dirty[sidx][hit_way] = 1'b1;
                                d.done                 = 1'b1;
                            end else begin
                                d.maddr  = blk_addr(ptag, sidx);
                                d.mwe    = 1'b1;
                                d.mbe    = lane_sel;
                                d.mwdata = lane_merged;
                                d.st     = CS_WTWR;
                            end
                        end
                    end else begin
                        d.misses  = q.misses + CNT_W'(1);
                        d.pending = 1'b1;
                        d.victim  = victim_way;
                        if (q.valid[sidx][victim_way] && q.dirty[sidx][victim_way]) begin
                            d.maddr  = blk_addr(q.tag[sidx][victim_way], sidx);
                            d.mwe    = 1'b1;
                            d.mbe    = '1;
                            d.mwdata = q.data[sidx][victim_way];
                            d.st     = CS_EVICT;
                        end else begin
                            d.maddr = blk_addr(ptag, sidx);
                            d.mwe   = 1'b0;
                            d.mbe   = '0;
                            d.st    = CS_FILL;
                        end
                    end
                end
            end
            CS_EVICT: begin
                if (mem_ack) begin
                    d.wrb                    = q.wrb + CNT_W'(BLK_BYTES);
                    d.valid[sidx][q.victim]  = 1'b0;
                    d.dirty[sidx][q.victim]  = 1'b0;
                    d.maddr                  = blk_addr(ptag, sidx);
                    d.mwe                    = 1'b0;
                    d.mbe                    = '0;
                    d.st                     = CS_FILL;
                end
            end
            CS_FILL: begin
                if (mem_ack) begin
                    d.rdb                   = q.rdb + CNT_W'(BLK_BYTES);
                    d.valid[sidx][q.victim] = 1'b1;
                    d.dirty[sidx][q.victim] = 1'b0;
                    d.tag[sidx][q.victim]   = ptag;
                    d.data[sidx][q.victim]  = mem_rdata;
                    d.lru[sidx]             = ~q.victim;
                    d.st                    = CS_IDLE;
                end
            end
            CS_WTWR: begin
                if (mem_ack) begin
                    d.wrb  = q.wrb + CNT_W'($countones(q.mbe));
                    d.mwe  = 1'b0;
                    d.done = 1'b1;
                    d.st   = CS_IDLE;
                end
            end
            default: d.st = CS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign cpu_done   = q.done;
    assign cpu_rdata  = q.rdata;
    assign mem_req    = (q.st != CS_IDLE);
    assign mem_we     = q.mwe;
    assign mem_addr   = q.maddr;
    assign mem_be     = q.mbe;
    assign mem_wdata  = q.mwdata;
    assign hit_count  = q.hits;
    assign miss_count = q.misses;
    assign rd_bytes   = q.rdb;
    assign wr_bytes   = q.wrb;

endmodule

// File: rtl/wb2_cache_chk.sv
module wb2_cache_chk #(
    parameter int ADDR_W     = 4,
    parameter int BLK_BYTES  = 2,
    parameter bit WRITE_BACK = 1'b1,
    parameter int CNT_W      = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 cpu_done,
    input logic                 mem_req,
    input logic                 mem_we,
    input logic                 mem_ack,
    input logic [ADDR_W-1:0]    mem_addr,
    input logic [BLK_BYTES-1:0] mem_be,
    input logic [CNT_W-1:0]     hit_count,
    input logic [CNT_W-1:0]     miss_count,
    input logic [CNT_W-1:0]     rd_bytes,
    input logic [CNT_W-1:0]     wr_bytes
);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        $fell(rst) |-> (hit_count == '0 && miss_count == '0 && rd_bytes == '0 &&
                        wr_bytes == '0 && !mem_req && !cpu_done));

    assert_req_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        cpu_done |=> !cpu_done);

    assert_read_step_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_bytes != $past(rd_bytes)) |->
            ($past(mem_ack) && !$past(mem_we) &&
             rd_bytes == $past(rd_bytes) + CNT_W'(BLK_BYTES)));

    assert_write_step_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_bytes != $past(wr_bytes)) |-> ($past(mem_ack) && $past(mem_we)));

    assert_one_outcome_R10: assert property (@(posedge clk) disable iff (rst)
        (hit_count != $past(hit_count)) |-> (miss_count == $past(miss_count)));

    if (WRITE_BACK) begin : g_wb
        assert_whole_block_R5: assert property (@(posedge clk) disable iff (rst)
            (mem_req && mem_we) |-> ($countones(mem_be) == BLK_BYTES));
    end else begin : g_wt
        assert_single_byte_R7: assert property (@(posedge clk) disable iff (rst)
            (mem_req && mem_we) |-> ($countones(mem_be) == 1));
    end

endmodule

bind wb2_cache wb2_cache_chk #(
    .ADDR_W     (ADDR_W),
    .BLK_BYTES  (BLK_BYTES),
    .WRITE_BACK (WRITE_BACK),
    .CNT_W      (CNT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cpu_done   (cpu_done),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_ack    (mem_ack),
    .mem_addr   (mem_addr),
    .mem_be     (mem_be),
    .hit_count  (hit_count),
    .miss_count (miss_count),
    .rd_bytes   (rd_bytes),
    .wr_bytes   (wr_bytes)
);

// File: tb/sim_wb2_cache.sv
`timescale 1ns/1ps
module sim_wb2_cache;

    localparam int AW = 4;
    localparam int BB = 2;
    localparam int BW = 8 * BB;
    localparam int CW = 16;
    localparam int MSZ = 16;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic          rst = 1'b1;
    logic          req0 = 1'b0, req1 = 1'b0;
    logic          we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wd = '0;

    logic          done0, done1;
    logic [7:0]    rdat0, rdat1;
    logic          mreq0, mreq1, mwe0, mwe1;
    logic [AW-1:0] maddr0, maddr1;
    logic [BB-1:0] mbe0, mbe1;
    logic [BW-1:0] mwd0, mwd1;
    logic [BW-1:0] mrd0 = '0, mrd1 = '0;
    logic          ack0 = 1'b0, ack1 = 1'b0;
    logic [CW-1:0] hit0, hit1, mis0, mis1, rdb0, rdb1, wrb0, wrb1;

    wb2_cache #(.WRITE_BACK(1'b1)) u0 (
        .clk(clk), .rst(rst), .cpu_req(req0), .cpu_we(we), .cpu_addr(addr),
        .cpu_wdata(wd), .cpu_done(done0), .cpu_rdata(rdat0),
        .mem_req(mreq0), .mem_we(mwe0), .mem_addr(maddr0), .mem_be(mbe0),
        .mem_wdata(mwd0), .mem_rdata(mrd0), .mem_ack(ack0),
        .hit_count(hit0), .miss_count(mis0), .rd_bytes(rdb0), .wr_bytes(wrb0)
    );

    wb2_cache #(.WRITE_BACK(1'b0)) u1 (
        .clk(clk), .rst(rst), .cpu_req(req1), .cpu_we(we), .cpu_addr(addr),
        .cpu_wdata(wd), .cpu_done(done1), .cpu_rdata(rdat1),
        .mem_req(mreq1), .mem_we(mwe1), .mem_addr(maddr1), .mem_be(mbe1),
        .mem_wdata(mwd1), .mem_rdata(mrd1), .mem_ack(ack1),
        .hit_count(hit1), .miss_count(mis1), .rd_bytes(rdb1), .wr_bytes(wrb1)
    );

    // Backing memories, two-cycle acknowledge, driven away from the active edge.
    logic [7:0] mem0 [MSZ];
    logic [7:0] mem1 [MSZ];
    int cnt0 = 0, cnt1 = 0;

    always @(negedge clk) begin
        if (ack0) begin
            ack0 = 1'b0; cnt0 = 0;
        end else if (mreq0) begin
            cnt0++;
            if (cnt0 == 2) begin
                if (mwe0) begin
                    for (int i = 0; i < BB; i++)
                        if (mbe0[i]) mem0[int'(maddr0) + i] = mwd0[i*8 +: 8];
                end else begin
                    for (int i = 0; i < BB; i++) mrd0[i*8 +: 8] = mem0[int'(maddr0) + i];
                end
                ack0 = 1'b1;
            end
        end
        if (ack1) begin
            ack1 = 1'b0; cnt1 = 0;
        end else if (mreq1) begin
            cnt1++;
            if (cnt1 == 2) begin
                if (mwe1) begin
                    for (int i = 0; i < BB; i++)
                        if (mbe1[i]) mem1[int'(maddr1) + i] = mwd1[i*8 +: 8];
                end else begin
                    for (int i = 0; i < BB; i++) mrd1[i*8 +: 8] = mem1[int'(maddr1) + i];
                end
                ack1 = 1'b1;
            end
        end
    end

    int checks = 0, errors = 0;
    bit finished = 1'b0;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Behavioural reference: recency queues of resident blocks, flat byte images.
    int         rq0[$], rq1[$];
    bit         dirty0 [MSZ/BB];
    int         eh[2], em[2], er[2], ew[2];
    logic [7:0] truth [MSZ];
    logic [7:0] exp0 [MSZ];
    logic [7:0] exp1 [MSZ];

    function automatic logic [7:0] init_byte(int i);
        return 8'(i * 37 + 11);
    endfunction

    task automatic model(int inst, bit w, int a, logic [7:0] v);
        int b;
        int found;
        int rq[$];
        b = a / BB;
        found = -1;
        if (inst == 0) rq = rq0; else rq = rq1;
        for (int i = 0; i < rq.size(); i++) if (rq[i] == b) found = i;
        if (found >= 0) begin
            eh[inst]++;
            rq.delete(found);
            rq.push_back(b);
        end else begin
            em[inst]++;
            if (rq.size() == 2) begin
                int vb;
                vb = rq.pop_front();
                if (inst == 0 && dirty0[vb]) begin
                    ew[0] += BB;
                    for (int i = 0; i < BB; i++) exp0[vb*BB + i] = truth[vb*BB + i];
                end
            end
            rq.push_back(b);
            er[inst] += BB;
            if (inst == 0) dirty0[b] = 1'b0;
        end
        if (w) begin
            if (inst == 0) dirty0[b] = 1'b1;
            else begin
                ew[1] += 1;
                exp1[a] = v;
            end
        end
        if (inst == 0) rq0 = rq; else rq1 = rq;
    endtask

    logic [7:0] got0, got1;

    task automatic access(bit w, int a, logic [7:0] v, string tag);
        bit g0, g1;
        int cyc, bad0, bad1;
        model(0, w, a, v);
        model(1, w, a, v);
        if (w) truth[a] = v;
        @(negedge clk);
        we = w; addr = AW'(a); wd = v;
        req0 = 1'b1; req1 = 1'b1;
        g0 = 1'b0; g1 = 1'b0; cyc = 0;
        while (!(g0 && g1) && cyc < 1000) begin
            @(negedge clk);
            cyc++;
            if (!g0 && done0) begin g0 = 1'b1; got0 = rdat0; req0 = 1'b0; end
            if (!g1 && done1) begin g1 = 1'b1; got1 = rdat1; req1 = 1'b0; end
        end
        req0 = 1'b0; req1 = 1'b0;
        chk({tag, " R11 completion strobe seen"}, int'(g0 && g1), 1);
        if (!w) begin
            chk({tag, " R2 R3 load data write-back"}, int'(got0), int'(truth[a]));
            chk({tag, " R7 load data write-through"}, int'(got1), int'(truth[a]));
        end
        chk({tag, " R2 hits write-back"}, int'(hit0), eh[0]);
        chk({tag, " R2 hits write-through"}, int'(hit1), eh[1]);
        chk({tag, " R3 misses write-back"}, int'(mis0), em[0]);
        chk({tag, " R3 misses write-through"}, int'(mis1), em[1]);
        chk({tag, " R3 bytes read write-back"}, int'(rdb0), er[0]);
        chk({tag, " R3 bytes read write-through"}, int'(rdb1), er[1]);
        chk({tag, " R5 bytes written write-back"}, int'(wrb0), ew[0]);
        chk({tag, " R7 bytes written write-through"}, int'(wrb1), ew[1]);
        bad0 = 0; bad1 = 0;
        for (int i = 0; i < MSZ; i++) begin
            if (mem0[i] !== exp0[i]) bad0++;
            if (mem1[i] !== exp1[i]) bad1++;
        end
        chk({tag, " R4 write-back memory image mismatches"}, bad0, 0);
        chk({tag, " R7 write-through memory image mismatches"}, bad1, 0);
    endtask

    initial begin
        for (int i = 0; i < MSZ; i++) begin
            mem0[i] = init_byte(i); mem1[i] = init_byte(i);
            truth[i] = init_byte(i); exp0[i] = init_byte(i); exp1[i] = init_byte(i);
        end
        for (int i = 0; i < MSZ/BB; i++) dirty0[i] = 1'b0;
        for (int i = 0; i < 2; i++) begin eh[i] = 0; em[i] = 0; er[i] = 0; ew[i] = 0; end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: quiet after reset
        chk("R1 hit count after reset", int'(hit0), 0);
        chk("R1 miss count after reset", int'(mis0), 0);
        chk("R1 read bytes after reset", int'(rdb0), 0);
        chk("R1 written bytes after reset", int'(wrb1), 0);
        chk("R1 no memory request after reset", int'(mreq0 | mreq1), 0);
        chk("R1 no completion after reset", int'(done0 | done1), 0);

        // R10: reference access sequence
        access(1'b0, 1, 8'h00, "seq ld1");
        chk("R1 first access misses", int'(mis0), 1);
        access(1'b0, 7, 8'h00, "seq ld7");
        access(1'b1, 0, 8'hA5, "seq st0");
        chk("R4 store hit leaves memory byte 0", int'(mem0[0]), int'(init_byte(0)));
        access(1'b1, 5, 8'h3C, "seq st5");
        access(1'b0, 10, 8'h00, "seq ld10");
        chk("R10 misses write-back", int'(mis0), 4);
        chk("R10 hits write-back", int'(hit0), 1);
        chk("R10 read bytes write-back", int'(rdb0), 8);
        chk("R10 written bytes write-back", int'(wrb0), 2);
        chk("R10 misses write-through", int'(mis1), 4);
        chk("R10 hits write-through", int'(hit1), 1);
        chk("R10 read bytes write-through", int'(rdb1), 8);
        chk("R10 written bytes write-through", int'(wrb1), 2);
        chk("R4 memory byte 5 still stale", int'(mem0[5]), int'(init_byte(5)));
        chk("R5 modified block 0 written back", int'(mem0[0]), 'hA5);
        chk("R7 write-through byte 5 in memory", int'(mem1[5]), 'h3C);

        // R5/R10: replace the remaining modified block
        access(1'b0, 12, 8'h00, "evict ld12");
        chk("R10 written bytes after final eviction", int'(wrb0), 4);
        chk("R5 byte 5 reaches memory on eviction", int'(mem0[5]), 'h3C);

        // R2: hit adds no traffic
        access(1'b0, 11, 8'h00, "hit ld11");
        chk("R2 hit adds no read traffic", int'(rdb0), 10);

        // R6/R9: clean victim dropped, recently used block kept
        access(1'b0, 0, 8'h00, "lru ld0");
        chk("R6 clean victim causes no write", int'(wrb0), 4);
        access(1'b0, 10, 8'h00, "lru ld10");
        chk("R9 recently used block stays resident", int'(hit0), 3);

        // R8: store miss allocates
        access(1'b1, 13, 8'h77, "alloc st13");
        chk("R8 store miss counted as miss", int'(mis0), 7);
        chk("R8 write-back memory untouched by store miss", int'(mem0[13]), int'(init_byte(13)));
        access(1'b0, 13, 8'h00, "alloc ld13");
        chk("R8 allocated byte reads back", int'(got0), 'h77);
        chk("R8 load after store miss hits", int'(hit0), 4);

        // Mixed sweep against the reference
        for (int k = 0; k < 40; k++) begin
            access((k % 3) == 1, (k * 7 + 3) % MSZ, 8'(k * 13 + 1), "sweep R9");
        end

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R11 watchdog expired actual 0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule